// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic and logic unit. It is made of a row of one-bit slices. Each slice can invert either of its operand bits. It forms the AND, OR and full-adder sum of the two conditioned bits, and a four-way selector picks that slice's result bit. The carry leaves each slice and enters the slice above it. The selector's fourth input is a "less" line. It is held low in every slice except bit 0, which receives the signed comparison outcome from the top slice.

A four-bit control word selects the operation. Bit 3 inverts operand a and bit 2 inverts operand b. Bit 2 also drives the carry into bit 0, so inverting b and adding one performs subtraction. Bits 1:0 pick the slice output. The AND path with both operands inverted gives NOR. Subtracting and then reading back the signed sign gives set-on-less-than. A zero flag reports an all-zero result, which is how equality is tested after a subtraction. An overflow flag reports signed overflow of an addition or a subtraction.

Top module: `bitslice_alu`

## Requirements
- R1: With ctrl_i = 4'b0000, result_o equals the bitwise AND of a_i and b_i.
- R2: With ctrl_i = 4'b0001, result_o equals the bitwise OR of a_i and b_i.
- R3: With ctrl_i = 4'b0010, result_o equals a_i + b_i modulo 2^W. The carry ripples from bit 0 to bit W-1 with a carry-in of 0.
- R4: With ctrl_i = 4'b0110, result_o equals a_i - b_i modulo 2^W. This is formed as a_i + ~b_i + 1.
- R5: With ctrl_i = 4'b0111, result_o[0] is 1 exactly when a_i < b_i as signed two's-complement numbers, and bits W-1:1 are 0. The comparison stays correct when a_i - b_i overflows, for example 0x80000000 against 0x7FFFFFFF.
- R6: With ctrl_i = 4'b1100, result_o equals the bitwise NOR of a_i and b_i.
- R7: zero_o is 1 exactly when every bit of result_o is 0, whatever the operation. After a subtraction it is 1 exactly when a_i equals b_i.
- R8: For ctrl_i = 4'b0010 or 4'b0110, overflow_o is 1 exactly when the signed result cannot be represented in W bits. It equals the carry into bit W-1 XOR the carry out of bit W-1. For other codes overflow_o carries no meaning.
- R9: Outputs follow the inputs with no clock and no storage: a change of a_i, b_i or ctrl_i is visible on the outputs once the logic settles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (32) | First operand |
| b_i | input | W (32) | Second operand |
| ctrl_i | input | 4 | {invert a, invert b / carry-in, select[1:0]} |
| result_o | output | W (32) | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow for add and subtract |

## Verification
The built-in checks sample settled values. They assume ctrl_i carries one of the six defined codes whenever an operation is meant to be judged, and that a_i and b_i have no unknown bits. The bench only ever drives the six legal codes and fully known operands. It changes inputs on the falling clock edge and judges outputs at the next rising edge, so every check sees a settled ripple chain. Overflow is judged only under add and subtract, the only codes for which it is defined.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned CTRL_W = 4;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    typedef struct packed {
        logic       flip_a;
        logic       flip_b;
        slice_sel_e sel;
    } alu_ctrl_t;

    localparam logic [CTRL_W-1:0] CODE_AND = 4'b0000;
    localparam logic [CTRL_W-1:0] CODE_OR  = 4'b0001;
    localparam logic [CTRL_W-1:0] CODE_ADD = 4'b0010;
    localparam logic [CTRL_W-1:0] CODE_SUB = 4'b0110;
    localparam logic [CTRL_W-1:0] CODE_SLT = 4'b0111;
    localparam logic [CTRL_W-1:0] CODE_NOR = 4'b1100;

    typedef struct packed {
        logic and_bit;
        logic or_bit;
        logic sum_bit;
        logic carry;
    } slice_paths_t;

    function automatic slice_paths_t bit_paths(input logic x, input logic y, input logic cin);
        slice_paths_t p;
        p.and_bit = x & y;
        p.or_bit  = x | y;
        p.sum_bit = x ^ y ^ cin;
        p.carry   = (x & y) | (x & cin) | (y & cin);
        return p;
    endfunction

    function automatic logic pick(input slice_sel_e s, input slice_paths_t p, input logic less);
        logic r;
        case (s)
            SEL_AND: r = p.and_bit;
            SEL_OR:  r = p.or_bit;
            SEL_SUM: r = p.sum_bit;
            default: r = less;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    input  alu_ctrl_t ctl,
    input  logic      carry_in,
    input  logic      less_in,
    output logic      res_bit,
    output logic      carry_out
);
    logic         a_c;
    logic         b_c;
    slice_paths_t paths;

    always_comb begin
        a_c       = a_bit ^ ctl.flip_a;
        b_c       = b_bit ^ ctl.flip_b;
        paths     = bit_paths(a_c, b_c, carry_in);
        res_bit   = pick(ctl.sel, paths, less_in);
        carry_out = paths.carry;
    end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    input  alu_ctrl_t ctl,
    input  logic      carry_in,
    input  logic      less_in,
    output logic      res_bit,
    output logic      sum_sign,
    output logic      ovf,
    output logic      signed_less
);
    logic         a_c;
    logic         b_c;
    slice_paths_t paths;

    always_comb begin
        a_c         = a_bit ^ ctl.flip_a;
        b_c         = b_bit ^ ctl.flip_b;
        paths       = bit_paths(a_c, b_c, carry_in);
        res_bit     = pick(ctl.sel, paths, less_in);
        sum_sign    = paths.sum_bit;
        ovf         = carry_in ^ paths.carry;
        signed_less = paths.sum_bit ^ ovf;
    end

    always_comb begin
        if (ovf) begin
            AST_OVF_SIGN_FLIP: assert ((a_c == b_c) && (sum_sign != a_c))
                else $error("overflow without sign flip"); // R8
        end
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);
    logic any_set;

    always_comb begin
        any_set = 1'b0;
        for (int k = 0; k < W; k++) begin
            any_set = any_set | value[k];
        end
        is_zero = ~any_set;
    end

    always_comb begin
        if (is_zero) begin
            AST_ZERO_NO_BITS: assert (value == '0) else $error("zero flag with set bits"); // R7
        end
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [W-1:0]      result_o,
    output logic              zero_o,
    output logic              overflow_o
);
    localparam int unsigned TOP = W - 1;

    alu_ctrl_t ctl;
    logic      carry [W];
    logic      less  [W];
    logic      top_sign;
    logic      top_ovf;
    logic      top_less;

    assign ctl      = alu_ctrl_t'(ctrl_i);
    assign carry[0] = ctl.flip_b;

    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i == 0) begin : g_lsb
            assign less[i] = top_less;
        end else begin : g_upper
            assign less[i] = 1'b0;
        end

        if (i == TOP) begin : g_msb
            alu_msb_slice u_msb (
                .a_bit       (a_i[i]),
                .b_bit       (b_i[i]),
                .ctl         (ctl),
                .carry_in    (carry[i]),
                .less_in     (less[i]),
                .res_bit     (result_o[i]),
                .sum_sign    (top_sign),
                .ovf         (top_ovf),
                .signed_less (top_less)
            );
        end else begin : g_mid
            alu_bit_slice u_bit (
                .a_bit     (a_i[i]),
                .b_bit     (b_i[i]),
                .ctl       (ctl),
                .carry_in  (carry[i]),
                .less_in   (less[i]),
                .res_bit   (result_o[i]),
                .carry_out (carry[i+1])
            );
        end
    end

    assign overflow_o = top_ovf;

    alu_zero_detect #(.W(W)) u_zero (
        .value   (result_o),
        .is_zero (zero_o)
    );

    always_comb begin
        case (ctrl_i)
            CODE_AND: begin
                AST_AND_MATCH: assert (result_o == (a_i & b_i)) else $error("and mismatch"); // R1
            end
            CODE_OR: begin
                AST_OR_MATCH: assert (result_o == (a_i | b_i)) else $error("or mismatch"); // R2
            end
            CODE_ADD: begin
                AST_ADD_MATCH: assert (result_o == W'(a_i + b_i)) else $error("add mismatch"); // R3
            end
            CODE_SUB: begin
                AST_SUB_MATCH: assert (result_o == W'(a_i - b_i)) else $error("sub mismatch"); // R4
                AST_SUB_ZERO_EQUAL: assert (zero_o == (a_i == b_i)) else $error("equality flag"); // R7
            end
            CODE_SLT: begin
                AST_SLT_UPPER_CLEAR: assert (result_o[W-1:1] == '0) else $error("slt upper bits"); // R5
                AST_SLT_SIGNED: assert (result_o[0] == ($signed(a_i) < $signed(b_i)))
                    else $error("slt compare"); // R5
            end
            CODE_NOR: begin
                AST_NOR_DEMORGAN: assert (result_o == ~(a_i | b_i)) else $error("nor mismatch"); // R6
            end
            default: ;
        endcase
    end
endmodule

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
    import alu_pkg::*;

    localparam int unsigned W = 32;
    localparam int unsigned ROW_W = 2*W + CTRL_W + W + 2;
    localparam int unsigned NROWS = 14;

    // {a, b, ctrl, expected result, expected zero, expected overflow}
    localparam logic [ROW_W-1:0] VEC [NROWS] = '{
        {32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000, 32'h00F0_1200, 1'b0, 1'b0},
        {32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001, 32'hFFF0_FF34, 1'b0, 1'b0},
        {32'h0000_0005, 32'h0000_0003, 4'b0010, 32'h0000_0008, 1'b0, 1'b0},
        {32'h0000_0005, 32'h0000_0003, 4'b0110, 32'h0000_0002, 1'b0, 1'b0},
        {32'h0000_0003, 32'h0000_0005, 4'b0110, 32'hFFFF_FFFE, 1'b0, 1'b0},
        {32'h0000_0003, 32'h0000_0005, 4'b0111, 32'h0000_0001, 1'b0, 1'b0},
        {32'h0000_0005, 32'h0000_0003, 4'b0111, 32'h0000_0000, 1'b1, 1'b0},
        {32'h8000_0000, 32'h7FFF_FFFF, 4'b0111, 32'h0000_0001, 1'b0, 1'b0},
        {32'h7FFF_FFFF, 32'h8000_0000, 4'b0111, 32'h0000_0000, 1'b1, 1'b0},
        {32'hF0F0_1234, 32'h0FF0_FF00, 4'b1100, 32'h000F_00CB, 1'b0, 1'b0},
        {32'h1234_5678, 32'h1234_5678, 4'b0110, 32'h0000_0000, 1'b1, 1'b0},
        {32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, 32'h0000_0000, 1'b1, 1'b0},
        {32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, 32'h8000_0000, 1'b0, 1'b1},
        {32'h8000_0000, 32'h0000_0001, 4'b0110, 32'h7FFF_FFFF, 1'b0, 1'b1}
    };

    localparam logic [CTRL_W-1:0] CODES [6] = '{CODE_AND, CODE_OR, CODE_ADD, CODE_SUB, CODE_SLT, CODE_NOR};

    logic              clk = 1'b0;
    logic [W-1:0]      a_i;
    logic [W-1:0]      b_i;
    logic [CTRL_W-1:0] ctrl_i;
    logic [W-1:0]      result_o;
    logic              zero_o;
    logic              overflow_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bitslice_alu #(.W(W)) u_bitslice_alu (
        .a_i        (a_i),
        .b_i        (b_i),
        .ctrl_i     (ctrl_i),
        .result_o   (result_o),
        .zero_o     (zero_o),
        .overflow_o (overflow_o)
    );

    function automatic string tag_of(input logic [CTRL_W-1:0] c);
        case (c)
            CODE_AND: return "R1";
            CODE_OR:  return "R2";
            CODE_ADD: return "R3";
            CODE_SUB: return "R4";
            CODE_SLT: return "R5";
            default:  return "R6";
        endcase
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [CTRL_W-1:0] c);
        case (c)
            CODE_AND: return a & b;
            CODE_OR:  return a | b;
            CODE_ADD: return a + b;
            CODE_SUB: return a - b;
            CODE_SLT: return {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default:  return ~(a | b);
        endcase
    endfunction

    function automatic logic model_ovf(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [CTRL_W-1:0] c);
        logic [W-1:0] r;
        r = (c == CODE_SUB) ? a - b : a + b;
        if (c == CODE_SUB) return (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
        return (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    endfunction

    task automatic check_vec(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h ctrl=%b actual=%h expected=%h", tag, a_i, b_i, ctrl_i, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [CTRL_W-1:0] c);
        @(negedge clk);
        a_i    = a;
        b_i    = b;
        ctrl_i = c;
        @(posedge clk);
    endtask

    task automatic judge(input logic [CTRL_W-1:0] c, input logic [W-1:0] er,
                         input logic ez, input logic eo);
        check_vec(tag_of(c), result_o, er);
        check_vec("R7", {{(W-1){1'b0}}, zero_o}, {{(W-1){1'b0}}, ez});
        if (c == CODE_ADD || c == CODE_SUB)
            check_vec("R8", {{(W-1){1'b0}}, overflow_o}, {{(W-1){1'b0}}, eo});
    endtask

    initial begin
        a_i    = '0;
        b_i    = '0;
        ctrl_i = CODE_AND;
        @(posedge clk);
        // initial state: all-zero inputs give a zero result and a raised zero flag (R7, R9)
        check_vec("R9", result_o, '0);
        check_vec("R7", {{(W-1){1'b0}}, zero_o}, {{(W-1){1'b0}}, 1'b1});

        for (int n = 0; n < NROWS; n++) begin
            logic [ROW_W-1:0] row;
            row = VEC[n];
            apply(row[ROW_W-1 -: W], row[ROW_W-1-W -: W], row[W+2 +: CTRL_W]);
            judge(row[W+2 +: CTRL_W], row[2 +: W], row[1], row[0]);
        end

        // R9: outputs track a change of control alone with the operands held
        apply(32'hAAAA_5555, 32'h5555_AAAA, CODE_OR);
        check_vec("R9", result_o, 32'hFFFF_FFFF);
        apply(32'hAAAA_5555, 32'h5555_AAAA, CODE_AND);
        check_vec("R9", result_o, 32'h0000_0000);

        // R5 corner: equal operands are not less
        apply(32'h8000_0000, 32'h8000_0000, CODE_SLT);
        check_vec("R5", result_o, '0);

        for (int n = 0; n < 300; n++) begin
            logic [W-1:0]      ra;
            logic [W-1:0]      rb;
            logic [CTRL_W-1:0] rc;
            ra = $urandom;
            rb = (n % 17 == 0) ? ra : $urandom;
            rc = CODES[n % 6];
            apply(ra, rb, rc);
            judge(rc, model(ra, rb, rc), (model(ra, rb, rc) == '0), model_ovf(ra, rb, rc));
        end
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 100000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule